// File: doc/BRIEF.md
# Serial configuration bitstream source

This block is the logic of a cascadable serial memory that loads an SRAM-based programmable device at power-up. It holds a fixed bitstream and sends it out one bit for each rising edge of a serial clock. The data pin has a drive enable, and the pin is released whenever the block is not selected or has finished sending.

A chain of these blocks shares one serial clock. The block chooses its role while the output-enable input is low. If chip select is low at that time, the block becomes the clock master: it produces the serial clock itself, from a divided system clock. If chip select is high at that time, the block becomes a follower: it takes the clock from its pin and detects that clock's rising edges through a synchronizer. When output enable goes low, the bit address returns to zero and the completion flag clears.

The stream contents are computed rather than stored as a table. The length of the stream, the word width and the clock divider are all parameters.

Top module: `cfg_stream_src`

## Requirements
- R1: While rst_ni is low, the block is in follower role and idle: sclk_oe_o=0, sclk_o=0, data_oe_o=0 and done_o=0.
- R2: data_oe_o is 1 exactly when oe_i=1, cs_ni=0 and the stream is not complete. When data_oe_o is 0, data_o reads 0.
- R3: While oe_i is low, the role follows cs_ni on each clock: cs_ni=0 gives master (sclk_oe_o=1) and cs_ni=1 gives follower (sclk_oe_o=0). While oe_i is high, the role does not change.
- R4: The stream is built from words of WORD_W bits. Word k has the value (37*k+90) mod 2^WORD_W, and each word is sent MSB first. Bit 0 of the stream is on data_o as soon as driving is enabled, before any clock edge.
- R5: Each qualifying rising edge of the serial clock advances the stream by exactly one bit. An edge qualifies when oe_i=1, cs_ni=0 and the stream is not complete.
- R6: Serial clock edges that arrive while cs_ni=1 do not advance the stream.
- R7: oe_i=0 returns the bit address to 0 and clears done_o within one clock.
- R8: After STREAM_BITS advances, done_o goes to 1 and data_oe_o goes to 0. Both hold through further serial clock edges until oe_i goes low.
- R9: In master role, while oe_i=1 and the stream is not complete, sclk_o toggles every CLK_DIV system clocks. Otherwise sclk_o is low.
- R10: In follower role, sclk_i passes through two synchronizer flops. A rising edge on sclk_i has advanced the stream within four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Output enable; a low level clears the address and lets the role be chosen |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the pin, used in follower role |
| sclk_o | output | 1 | Serial clock produced in master role |
| sclk_oe_o | output | 1 | Drive enable for the serial clock pin (master role) |
| data_o | output | 1 | Serial data |
| data_oe_o | output | 1 | Drive enable for serial data |
| done_o | output | 1 | Whole stream sent |

## Verification
The bench checks the first bit before any clock edge. A design that updates its output only on an edge would show a stale or zero bit there. The bench sends edges while the block is deselected, then selects it again and expects the same bit. A design that counts regardless of chip select would have moved on. It changes chip select while output enable is high and expects the role to stay the same. It also sends edges after the last bit and expects the data pin to stay released and the completion flag to stay set; a counter that wraps or overruns would drive data again. Finally, it drops output enable in the middle of the stream and expects the clock to go low and the stream to restart from bit 0.

// File: rtl/cfg_src_pkg.sv
package cfg_src_pkg;
  typedef enum logic {ROLE_FOLLOW = 1'b0, ROLE_MASTER = 1'b1} role_e;

  // word k = 37*k+90 (mod 2^w), MSB first
  function automatic logic stream_bit(int unsigned idx, int unsigned w);
    int unsigned word;
    word = (idx / w) * 37 + 90;
    return logic'((word >> (w - 1 - (idx % w))) & 1);
  endfunction
endpackage

// File: rtl/cfg_src_clkgen.sv
module cfg_src_clkgen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          tick;

  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) sclk_q <= ~sclk_q;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = run_i & tick & ~sclk_q;
endmodule

// File: rtl/cfg_src_sync.sv
module cfg_src_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cfg_src_addr.sv
module cfg_src_addr #(
  parameter int unsigned STREAM_BITS = 40,
  localparam int unsigned CW = $clog2(STREAM_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(STREAM_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (adv_i && !done_o)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfg_stream_src.sv
module cfg_stream_src #(
  parameter int unsigned STREAM_BITS = 40,
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned CLK_DIV     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic sclk_o,
  output logic sclk_oe_o,
  output logic data_o,
  output logic data_oe_o,
  output logic done_o
);
  import cfg_src_pkg::*;

  localparam int unsigned CW = $clog2(STREAM_BITS + 1);

  role_e         role_q;
  logic          gen_rise, ext_rise, edge_ev;
  logic [CW-1:0] cnt;
  logic          done;

  // role follows cs while oe is low, frozen once oe is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    role_q <= ROLE_FOLLOW;
    else if (!oe_i) role_q <= cs_ni ? ROLE_FOLLOW : ROLE_MASTER;
  end

  cfg_src_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (oe_i && role_q == ROLE_MASTER && !done),
    .sclk_o (sclk_o),
    .rise_o (gen_rise)
  );

  cfg_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sclk_i),
    .rise_o  (ext_rise)
  );

  assign edge_ev = (role_q == ROLE_MASTER) ? gen_rise : ext_rise;

  cfg_src_addr #(.STREAM_BITS(STREAM_BITS)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!oe_i),
    .adv_i  (oe_i && !cs_ni && edge_ev),
    .cnt_o  (cnt),
    .done_o (done)
  );

  assign sclk_oe_o = (role_q == ROLE_MASTER);
  assign data_oe_o = oe_i & ~cs_ni & ~done;
  assign data_o    = data_oe_o & stream_bit(32'(cnt), WORD_W);
  assign done_o    = done;
endmodule

// File: rtl/cfg_stream_src_chk.sv
module cfg_stream_src_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic oe_i,
  input logic cs_ni,
  input logic sclk_o,
  input logic sclk_oe_o,
  input logic data_oe_o,
  input logic done_o
);
  a_r2_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);

  a_r3_role_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> $stable(sclk_oe_o));

  a_r7_oe_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !done_o);

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && oe_i) |=> done_o);

  a_r8_done_releases_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !data_oe_o);

  a_r9_clk_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !sclk_o);
endmodule

bind cfg_stream_src cfg_stream_src_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_i      (oe_i),
  .cs_ni     (cs_ni),
  .sclk_o    (sclk_o),
  .sclk_oe_o (sclk_oe_o),
  .data_oe_o (data_oe_o),
  .done_o    (done_o)
);

// File: tb/cfg_stream_src_tb_top.sv
module cfg_stream_src_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 40;
  localparam int WW    = 8;
  localparam int DIV   = 2;
  localparam int EXP_DONE = 2;

  logic clk = 1'b0, rst_ni = 1'b0, oe_i = 1'b0, cs_ni = 1'b0, sclk_i = 1'b0;
  logic sclk_o, sclk_oe_o, data_o, data_oe_o, done_o;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit mon_en = 1'b0, slave_req = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_src #(.STREAM_BITS(NBITS), .WORD_W(WW), .CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .oe_i(oe_i), .cs_ni(cs_ni), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .done_o(done_o)
  );

  function automatic int exp_bit(int i);
    int word = (i / WW) * 37 + 90;
    return (word >> (WW - 1 - (i % WW))) & 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_item(int e, string req);
    if (e == EXP_DONE) begin
      chk(done_o === 1'b1, req, "done_o", int'(done_o), 1);
      chk(data_oe_o === 1'b0, req, "data_oe_o after done", int'(data_oe_o), 0);
    end else begin
      chk(data_oe_o === 1'b1, req, "data_oe_o", int'(data_oe_o), 1);
      chk(data_o === 1'(e), req, "data_o", int'(data_o), e);
    end
  endtask

  // monitor: master edges and follower requests
  initial begin
    bit prev = 1'b0;
    int gap = 0;
    bit have_rise = 1'b0;
    forever begin
      @(negedge clk);
      gap++;
      if (mon_en && sclk_o && !prev) begin
        if (have_rise) chk(gap == 2*DIV, "R9", "master clock period", gap, 2*DIV);
        have_rise = 1'b1;
        gap = 0;
        if (exp_q.size() > 0) cmp_item(exp_q.pop_front(), "R5");
        else cmp_item(EXP_DONE, "R8");
      end
      if (!mon_en) have_rise = 1'b0;
      prev = sclk_o;
      if (slave_req) begin
        slave_req = 1'b0;
        if (exp_q.size() > 0) cmp_item(exp_q.pop_front(), "R10");
        else chk(1'b0, "R10", "scoreboard underflow", 0, 1);
      end
    end
  end

  task automatic ext_pulse(int exp);
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
    if (exp >= 0) begin
      exp_q.push_back(exp);
      #1 slave_req = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(sclk_oe_o === 1'b0, "R1", "sclk_oe_o in reset", int'(sclk_oe_o), 0);
    chk(sclk_o === 1'b0, "R1", "sclk_o in reset", int'(sclk_o), 0);
    chk(data_oe_o === 1'b0, "R1", "data_oe_o in reset", int'(data_oe_o), 0);
    chk(done_o === 1'b0, "R1", "done_o in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk_oe_o === 1'b1, "R3", "master chosen with cs low", int'(sclk_oe_o), 1);
    chk(data_oe_o === 1'b0, "R2", "released while oe low", int'(data_oe_o), 0);

    // master full run
    for (int i = 1; i < NBITS; i++) exp_q.push_back(exp_bit(i));
    mon_en = 1'b1;
    oe_i = 1'b1;
    #1 cmp_item(exp_bit(0), "R4");
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    mon_en = 1'b0;
    chk(exp_q.size() == 0, "R5", "bits left unsent", exp_q.size(), 0);
    chk(done_o === 1'b1, "R8", "done held", int'(done_o), 1);
    chk(data_oe_o === 1'b0, "R8", "data released after done", int'(data_oe_o), 0);
    chk(sclk_o === 1'b0, "R9", "clock low after done", int'(sclk_o), 0);

    // R7 mid-stream clear
    oe_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(done_o === 1'b0, "R7", "done cleared", int'(done_o), 0);
    oe_i = 1'b1;
    repeat (30) @(negedge clk);
    oe_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk_o === 1'b0, "R9", "clock low while oe low", int'(sclk_o), 0);
    oe_i = 1'b1;
    #1 cmp_item(exp_bit(0), "R7");

    // R6 master clock running while deselected
    @(negedge clk);
    oe_i = 1'b0;
    repeat (2) @(negedge clk);
    oe_i = 1'b1;
    @(negedge clk);
    cs_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(data_oe_o === 1'b0, "R2", "released while cs high", int'(data_oe_o), 0);
    chk(sclk_oe_o === 1'b1, "R3", "role held while oe high", int'(sclk_oe_o), 1);
    cs_ni = 1'b0;
    #1 cmp_item(exp_bit(0), "R6");

    // follower role
    @(negedge clk);
    oe_i = 1'b0; cs_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk_oe_o === 1'b0, "R3", "follower chosen with cs high", int'(sclk_oe_o), 0);
    oe_i = 1'b1;
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk_oe_o === 1'b0, "R3", "follower held after cs low", int'(sclk_oe_o), 0);
    chk(sclk_o === 1'b0, "R9", "no clock in follower role", int'(sclk_o), 0);
    cmp_item(exp_bit(0), "R4");
    for (int i = 1; i <= 5; i++) ext_pulse(exp_bit(i));
    cs_ni = 1'b1;
    for (int i = 0; i < 3; i++) ext_pulse(-1);
    chk(data_oe_o === 1'b0, "R2", "released while deselected", int'(data_oe_o), 0);
    cs_ni = 1'b0;
    #1 cmp_item(exp_bit(5), "R6");
    for (int i = 6; i < NBITS; i++) ext_pulse(exp_bit(i));
    ext_pulse(EXP_DONE);
    ext_pulse(EXP_DONE);
    chk(exp_q.size() == 0, "R10", "follower scoreboard drained", exp_q.size(), 0);
    oe_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(done_o === 1'b0, "R7", "done cleared in follower role", int'(done_o), 0);
    summary();
  end
endmodule